// File: doc/BRIEF.md
# Chip Erase-and-Verify Sequencer

This block sits on the host side of a byte-wide flash device and runs a full chip-erase algorithm over the device's command interface. When it sees a start pulse, it writes the erase command twice. The first write arms the erase and the second write begins it. The sequencer then waits a fixed number of clocks while the erase runs. After that it checks the array byte by byte, starting at address zero. Each check is a verify command write that carries the byte address, followed by a read of that address.

A byte that reads back as FFH is blank, and the sequencer moves on to the next address. A byte that reads back as anything else starts another erase. Checking then picks up again at that same byte, and the bytes already checked are not read again. When the highest address passes, the sequencer writes a terminating command and raises `done`. If a byte is still not blank after the allowed number of re-erases, the sequencer raises `error` and stops.

All bus strobes are generated in the system clock domain. The erase soak timer and the retry counter are inside the block.

Top module: `erase_verify_seq`

## Requirements
- R1: After reset, `busy`, `done` and `error` are low, and both `fl_we_n` and `fl_oe_n` are high.
- R2: A `start` pulse while idle (or while `done` or `error` is shown) makes `busy` high in the next cycle. The first two bus writes of a run both carry data 20H.
- R3: Every bus write holds `fl_we_n` low for at least two clocks. `fl_addr` and `fl_wdata` stay unchanged from the falling edge of the strobe to its rising edge. `fl_we_n` and `fl_oe_n` are never low together.
- R4: After the second 20H write, at least ERASE_CYC clocks pass before the next write strobe falls.
- R5: Each byte check is a write of A0H to the byte's address, followed by one read (`fl_oe_n` low) of that same address. No read happens without a fresh A0H write in front of it.
- R6: A byte passes when the read returns FFH. Bytes are checked in ascending order, from address 0 up to 2^AW-1.
- R7: When a read returns a value other than FFH, the next write is 20H, which starts a new erase. The next A0H write after that erase goes to the failing address. No byte that already passed is read again.
- R8: After the highest address passes, exactly one write of EXIT_CMD (default 40H) is made. Then `done` goes high and `busy` goes low. `done` stays high until the next `start`.
- R9: When a byte fails and MAX_RETRY re-erases have already been made in the run, `error` goes high, `busy` goes low, and no further bus write is made. `error` stays high until the next `start`.
- R10: A `start` pulse while `busy` is high has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a chip erase |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High when the last run ended with every byte blank |
| error | output | 1 | High when the last run ran out of retries |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Command byte driven during writes |
| fl_rdata | input | 8 | Data returned by the flash during reads |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_oe_n | output | 1 | Active-low output enable for reads |

## Verification
The flash model in the bench gives each byte a number of erases it needs before it reads blank. From that, the bench works out the exact erase count and read count that a resume-in-place scan must produce. A design that rescanned from address 0 would make extra reads. A design that skipped the re-erase would finish with too few erases.

The bench covers these corner cases:
- a stubborn byte at the first address and another at the last address;
- a byte that needs exactly the retry limit plus one erase, which must still pass;
- a byte that needs one erase more than that, which must end in `error` with no terminating write;
- a start pulse in the middle of a run, which must change nothing.

The model also reports a read that has no fresh verify write in front of it, an address or data change while the write strobe is low, and a soak time shorter than ERASE_CYC.

// File: rtl/evs_pkg.sv
package evs_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_ARM, S_EXEC, S_SOAK, S_VCMD, S_VRD, S_EXIT, S_DONE, S_FAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD
    } bus_phase_e;

    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_VERIFY = 8'hA0;
    localparam logic [7:0] BYTE_BLANK = 8'hFF;

endpackage

// File: rtl/evs_bus_cycler.sv
module evs_bus_cycler
    import evs_pkg::*;
#(
    parameter int AW         = 4,
    parameter int STROBE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    output logic          ack_o,
    output logic [7:0]    rdata_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [7:0]    bus_wdata_o,
    output logic          bus_we_n_o,
    output logic          bus_oe_n_o,
    input  logic [7:0]    bus_rdata_i
);

    localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

    typedef struct packed {
        bus_phase_e    phase;
        logic          rd;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [CW-1:0] cnt;
        logic [7:0]    rdata;
    } cyc_t;

    cyc_t cyc_d, cyc_q;

    always_comb begin
        cyc_d = cyc_q;
        unique case (cyc_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    cyc_d.phase = PH_SETUP;
                    cyc_d.rd    = rd_i;
                    cyc_d.addr  = addr_i;
                    cyc_d.data  = data_i;
                    cyc_d.cnt   = CW'(STROBE_CYC - 1);
                end
            end
            PH_SETUP: cyc_d.phase = PH_STROBE;
            PH_STROBE: begin
                if (cyc_q.cnt == '0) begin
                    cyc_d.phase = PH_HOLD;
                    if (cyc_q.rd) begin
                        cyc_d.rdata = bus_rdata_i;
                    end
                end else begin
                    cyc_d.cnt = cyc_q.cnt - 1'b1;
                end
            end
            PH_HOLD: cyc_d.phase = PH_IDLE;
            default: cyc_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '{phase: PH_IDLE, rd: 1'b0, addr: '0, data: '0, cnt: '0, rdata: '0};
        end else begin
            cyc_q <= cyc_d;
        end
    end

    assign ack_o       = (cyc_q.phase == PH_HOLD);
    assign rdata_o     = cyc_q.rdata;
    assign bus_addr_o  = cyc_q.addr;
    assign bus_wdata_o = cyc_q.data;
    assign bus_we_n_o  = !((cyc_q.phase == PH_STROBE) && !cyc_q.rd);
    assign bus_oe_n_o  = !((cyc_q.phase == PH_STROBE) && cyc_q.rd);

endmodule

// File: rtl/evs_soak_timer.sv
module evs_soak_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);

    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = TW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/erase_verify_seq.sv
module erase_verify_seq
    import evs_pkg::*;
#(
    parameter int          AW        = 4,
    parameter int          ERASE_CYC = 64,
    parameter int          MAX_RETRY = 1000,
    parameter int          WE_CYC    = 2,
    parameter logic [7:0]  EXIT_CMD  = 8'h40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_wdata,
    input  logic [7:0]    fl_rdata,
    output logic          fl_we_n,
    output logic          fl_oe_n
);

    localparam int          TW        = $clog2(MAX_RETRY + 1);
    localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] addr;
        logic [TW-1:0] tries;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          bus_req, bus_rd, bus_ack, soak_load, soak_done;
    logic [AW-1:0] bus_a;
    logic [7:0]    bus_cmd, bus_rdata;

    always_comb begin
        seq_d     = seq_q;
        bus_req   = 1'b0;
        bus_rd    = 1'b0;
        bus_cmd   = 8'h00;
        bus_a     = seq_q.addr;
        soak_load = 1'b0;
        unique case (seq_q.state)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) begin
                    seq_d.state = S_ARM;
                    seq_d.addr  = '0;
                    seq_d.tries = '0;
                end
            end
            S_ARM: begin
                bus_req = 1'b1;
                bus_cmd = CMD_ERASE;
                bus_a   = '0;
                if (bus_ack) seq_d.state = S_EXEC;
            end
            S_EXEC: begin
                bus_req = 1'b1;
                bus_cmd = CMD_ERASE;
                bus_a   = '0;
                if (bus_ack) begin
                    seq_d.state = S_SOAK;
                    soak_load   = 1'b1;
                end
            end
            S_SOAK: begin
                if (soak_done) seq_d.state = S_VCMD;
            end
            S_VCMD: begin
                bus_req = 1'b1;
                bus_cmd = CMD_VERIFY;
                if (bus_ack) seq_d.state = S_VRD;
            end
            S_VRD: begin
                bus_req = 1'b1;
                bus_rd  = 1'b1;
                if (bus_ack) begin
                    if (bus_rdata == BYTE_BLANK) begin
                        if (seq_q.addr == LAST_ADDR) begin
                            seq_d.state = S_EXIT;
                        end else begin
                            seq_d.addr  = seq_q.addr + 1'b1;
                            seq_d.state = S_VCMD;
                        end
                    end else if (seq_q.tries == TW'(MAX_RETRY)) begin
                        seq_d.state = S_FAIL;
                    end else begin
                        seq_d.tries = seq_q.tries + 1'b1;
                        seq_d.state = S_ARM;
                    end
                end
            end
            S_EXIT: begin
                bus_req = 1'b1;
                bus_cmd = EXIT_CMD;
                bus_a   = '0;
                if (bus_ack) seq_d.state = S_DONE;
            end
            default: seq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: S_IDLE, addr: '0, tries: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    evs_bus_cycler #(
        .AW         (AW),
        .STROBE_CYC (WE_CYC)
    ) u_cycler (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (bus_req),
        .rd_i        (bus_rd),
        .addr_i      (bus_a),
        .data_i      (bus_cmd),
        .ack_o       (bus_ack),
        .rdata_o     (bus_rdata),
        .bus_addr_o  (fl_addr),
        .bus_wdata_o (fl_wdata),
        .bus_we_n_o  (fl_we_n),
        .bus_oe_n_o  (fl_oe_n),
        .bus_rdata_i (fl_rdata)
    );

    evs_soak_timer #(
        .CYCLES (ERASE_CYC)
    ) u_soak (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (soak_load),
        .expired_o (soak_done)
    );

    assign busy  = !(seq_q.state inside {S_IDLE, S_DONE, S_FAIL});
    assign done  = (seq_q.state == S_DONE);
    assign error = (seq_q.state == S_FAIL);

endmodule

// File: rtl/evs_checker.sv
module evs_checker #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_wdata,
    input logic          fl_we_n,
    input logic          fl_oe_n
);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done && !error && fl_we_n && fl_oe_n));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> !$past(fl_we_n, 2));

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error) && !(busy && (done || error)));

    p_error_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> (error && fl_we_n));

endmodule

bind erase_verify_seq evs_checker #(.AW(AW)) u_evs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_we_n  (fl_we_n),
    .fl_oe_n  (fl_oe_n)
);

// File: tb/test_erase_verify_seq.sv
module test_erase_verify_seq;

    localparam int         AW        = 4;
    localparam int         N         = 1 << AW;
    localparam int         ERASE_CYC = 12;
    localparam int         MAX_RETRY = 5;
    localparam logic [7:0] EXIT_CMD  = 8'h40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, error, fl_we_n, fl_oe_n;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata, fl_rdata;

    int total = 0;
    int bad   = 0;

    // flash model state
    int            need [N];
    int            erase_ops, reads, viol, order_viol, exit_writes, short_soak, writes_total;
    int            lowcnt;
    bit            verify_mode, fresh, armed, expect_erase, in_soak;
    logic [AW-1:0] vaddr, exp_vaddr, fall_addr;
    logic [7:0]    fall_data;
    logic [7:0]    first_w [2];
    realtime       exec_t;

    always #5 clk = ~clk;

    erase_verify_seq #(
        .AW        (AW),
        .ERASE_CYC (ERASE_CYC),
        .MAX_RETRY (MAX_RETRY),
        .WE_CYC    (2),
        .EXIT_CMD  (EXIT_CMD)
    ) i_erase_verify_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .done     (done),
        .error    (error),
        .fl_addr  (fl_addr),
        .fl_wdata (fl_wdata),
        .fl_rdata (fl_rdata),
        .fl_we_n  (fl_we_n),
        .fl_oe_n  (fl_oe_n)
    );

    assign fl_rdata = !verify_mode ? 8'h00 :
                      (erase_ops >= need[fl_addr]) ? 8'hFF : 8'h5A;

    always @(posedge clk) begin
        if (!fl_we_n) lowcnt = lowcnt + 1;
        else          lowcnt = 0;
    end

    always @(negedge fl_we_n) begin
        fall_addr = fl_addr;
        fall_data = fl_wdata;
        if (in_soak) begin
            if ($realtime - exec_t < ERASE_CYC * 10.0) short_soak++;
            in_soak = 0;
        end
    end

    always @(posedge fl_we_n) begin
        if (fl_addr !== fall_addr || fl_wdata !== fall_data) viol++;
        if (lowcnt < 2) viol++;
        if (writes_total < 2) first_w[writes_total] = fl_wdata;
        writes_total++;
        if (expect_erase && fl_wdata != 8'h20) order_viol++;
        if (fl_wdata == 8'h20) begin
            if (armed) begin
                erase_ops++;
                armed        = 0;
                exec_t       = $realtime;
                in_soak      = 1;
                verify_mode  = 0;
                expect_erase = 0;
            end else begin
                armed = 1;
            end
        end else if (fl_wdata == 8'hA0) begin
            armed       = 0;
            verify_mode = 1;
            vaddr       = fl_addr;
            fresh       = 1;
            if (fl_addr != exp_vaddr) order_viol++;
        end else begin
            armed       = 0;
            verify_mode = 0;
            if (fl_wdata == EXIT_CMD) exit_writes++;
        end
    end

    always @(negedge fl_oe_n) begin
        if (!(verify_mode && fresh && fl_addr == vaddr)) viol++;
        fresh = 0;
        reads++;
    end

    always @(posedge fl_oe_n) begin
        if (fl_rdata == 8'hFF) exp_vaddr = exp_vaddr + 1'b1;
        else                   expect_erase = 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        erase_ops = 0; reads = 0; viol = 0; order_viol = 0; exit_writes = 0;
        short_soak = 0; writes_total = 0;
        verify_mode = 0; fresh = 0; armed = 0; expect_erase = 0; in_soak = 0;
        exp_vaddr = '0; first_w[0] = 8'h00; first_w[1] = 8'h00;
    endtask

    // expected erase and read counts of a resume-in-place scan
    function automatic void ref_run(output int e, output int r, output bit err);
        e = 1; r = 0; err = 0;
        for (int i = 0; i < N; i++) begin
            while (e < need[i]) begin
                r++;
                if (e - 1 == MAX_RETRY) begin
                    err = 1;
                    return;
                end
                e++;
            end
            r++;
        end
    endfunction

    task automatic run_case(input string name, input bit poke);
        int  exp_e, exp_r, cyc;
        bit  exp_err;
        ref_run(exp_e, exp_r, exp_err);
        clear_model();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, {"R2 busy after start ", name}, busy, 1);
        cyc = 0;
        while (!(done || error)) begin
            @(negedge clk);
            cyc++;
            if (poke) start = (cyc == 30);
        end
        start = 1'b0;
        chk(error == exp_err, {"R9 error flag ", name}, error, exp_err);
        chk(done == !exp_err, {"R8 done flag ", name}, done, !exp_err);
        chk(busy == 1'b0, {"R8 busy low at end ", name}, busy, 0);
        chk(erase_ops == exp_e, {"R7 erase count ", name}, erase_ops, exp_e);
        chk(reads == exp_r, {"R7 R10 read count ", name}, reads, exp_r);
        chk(viol == 0, {"R3 R5 strobe/verify protocol ", name}, viol, 0);
        chk(order_viol == 0, {"R6 R7 address order ", name}, order_viol, 0);
        chk(short_soak == 0, {"R4 soak length ", name}, short_soak, 0);
        chk(first_w[0] == 8'h20 && first_w[1] == 8'h20, {"R2 arm/exec data ", name},
            {first_w[0], first_w[1]}, 16'h2020);
        chk(exit_writes == (exp_err ? 0 : 1), {"R8 R9 exit writes ", name},
            exit_writes, exp_err ? 0 : 1);
        repeat (5) @(negedge clk);
        chk(done == !exp_err && error == exp_err && fl_we_n,
            {"R8 R9 flag hold ", name}, {done, error}, {!exp_err, exp_err});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_model();
        lowcnt = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error && fl_we_n && fl_oe_n, "R1 reset state",
            {busy, done, error, fl_we_n, fl_oe_n}, 5'b00011);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !error, "R1 idle after reset", {busy, done, error}, 0);

        foreach (need[i]) need[i] = 1;
        run_case("all blank", 1'b0);

        for (int k = 0; k < 4; k++) begin
            foreach (need[i]) need[i] = $urandom_range(1, 3);
            run_case("random", 1'b0);
        end

        foreach (need[i]) need[i] = 1;
        need[0] = 3;
        run_case("first stubborn", 1'b0);

        foreach (need[i]) need[i] = 1;
        need[N-1] = 4;
        run_case("last stubborn", 1'b0);

        foreach (need[i]) need[i] = 1;
        need[5] = MAX_RETRY + 1;
        run_case("limit boundary", 1'b0);

        foreach (need[i]) need[i] = 1;
        need[7] = MAX_RETRY + 2;
        run_case("R9 exceeded", 1'b0);

        foreach (need[i]) need[i] = $urandom_range(1, 2);
        run_case("R10 start while busy", 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule